// File: doc/BRIEF.md
# Paged Stack Pointer with Frame Sequencer

This block holds the stack pointer of a small 8-bit processor and drives the stack side of memory traffic. The pointer is 16 bits wide. Its upper byte is a constant page number (01h by default) and only the low byte moves, so the stack lives in one 256-byte page. The pointer always names the next free byte. A write goes to the current pointer, which then steps down. A read first steps the pointer up, then reads there. Leaving the page at either end wraps silently to the other end.

The processor issues one command at a time: push one byte, pop one byte, subroutine call, subroutine return, interrupt entry, interrupt return, reset the stack, or load the low byte. Call and interrupt commands take their context values (program counter, index, accumulator, condition code) as inputs. The block then produces one memory byte per clock, each with an address, a write or read strobe, write data and a slot code that names the context register the byte belongs to. While a frame is in progress, `busy_o` is high and new commands are dropped. The memory array and instruction decode sit outside the block.

Top module: `stk_engine`

## Requirements
- R1: After reset `sp_o` is 01FFh, and `busy_o`, `mem_we_o` and `mem_re_o` are low.
- R2: The upper byte of `sp_o` and of every strobed `mem_addr_o` is always the page number 01h.
- R3: A push (`cmd_i`=1) writes `data_i` at address `sp_o` with slot code 5, and then `sp_o` drops by one.
- R4: A pop (`cmd_i`=2) raises the low byte of `sp_o` by one and reads at the new value, with slot code 5.
- R5: The low byte wraps modulo 256 in both directions (a push at 0100h leaves 01FFh; a pop at 01FFh reads 0100h) and nothing flags it.
- R6: A load (`cmd_i`=8) sets `sp_o` to {01h, `data_i`}. A stack reset (`cmd_i`=7) sets `sp_o` to 01FFh. Neither makes a memory access.
- R7: A call (`cmd_i`=3) writes two bytes at descending addresses: PC low (slot 0), then PC high (slot 1). The pointer ends two lower.
- R8: An interrupt entry (`cmd_i`=5) writes five bytes at descending addresses. The order is PC low (slot 0), PC high (slot 1), X (slot 2), A (slot 3), CC (slot 4), and the first byte goes at the pointer value the command found.
- R9: An interrupt return (`cmd_i`=6) reads five bytes at ascending addresses with slots in the order 4, 3, 2, 1, 0. A subroutine return (`cmd_i`=4) reads two bytes with slots 1 then 0.
- R10: Exactly one byte is moved per clock. `busy_o` stays high for exactly the cycles that carry a frame byte. A command presented while `busy_o` is high is ignored and changes neither the pointer nor the memory traffic.
- R11: The first strobe of a frame appears in the cycle after the command is accepted, and `cmd_i`=0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_i | input | 4 | Command code (see requirements) |
| data_i | input | 8 | Push byte or new pointer low byte |
| pc_i | input | 16 | Program counter for call and interrupt entry |
| x_i | input | 8 | Index register value for interrupt entry |
| a_i | input | 8 | Accumulator value for interrupt entry |
| cc_i | input | 8 | Condition code value for interrupt entry |
| sp_o | output | 16 | Current stack pointer |
| mem_addr_o | output | 16 | Stack memory address |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_wdata_o | output | 8 | Write data |
| slot_o | output | 3 | Context register code of the current byte |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: 8-bit data, an 8-bit page field and page number 01h. With those values the 256-byte wrap is reached with a single load of the low byte, so wrap during push, pop and a five-byte interrupt frame that straddles the page bottom can each be reached in a few cycles. The scoreboard predicts the address, direction, data and slot of every byte from a separate pointer model. It therefore catches frame reordering, missing or extra strobes, and commands that should have been dropped while busy.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_PUSH = 4'd1,
    CMD_POP  = 4'd2,
    CMD_CALL = 4'd3,
    CMD_RET  = 4'd4,
    CMD_INT  = 4'd5,
    CMD_IRET = 4'd6,
    CMD_RSP  = 4'd7,
    CMD_LOAD = 4'd8
  } stk_cmd_e;

  typedef enum logic [2:0] {
    SL_PCL  = 3'd0,
    SL_PCH  = 3'd1,
    SL_X    = 3'd2,
    SL_A    = 3'd3,
    SL_CC   = 3'd4,
    SL_DATA = 3'd5
  } stk_slot_e;

  localparam int FRAME_MAX = 5;
  localparam int IDX_W     = $clog2(FRAME_MAX);
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter int LO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rsp_i,
  input  logic            ld_i,
  input  logic [LO_W-1:0] ld_val_i,
  input  logic            dec_i,
  input  logic            inc_i,
  output logic [LO_W-1:0] lo_o
);
  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lo_q <= '1;
    else if (rsp_i) lo_q <= '1;
    else if (ld_i)  lo_q <= ld_val_i;
    else if (dec_i) lo_q <= lo_q - 1'b1;  // wraps silently
    else if (inc_i) lo_q <= lo_q + 1'b1;
  end

  assign lo_o = lo_q;
endmodule

// File: rtl/stk_frame_seq.sv
module stk_frame_seq
  import stk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  stk_cmd_e          cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [2*DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] cc_i,
  output logic              active_o,
  output logic              push_o,
  output logic [DATA_W-1:0] byte_o,
  output stk_slot_e         slot_o
);
  logic [DATA_W-1:0] dbuf_d [FRAME_MAX];
  stk_slot_e         sbuf_d [FRAME_MAX];
  logic [IDX_W-1:0]  last_d;
  logic              push_d;

  logic [DATA_W-1:0] dbuf_q [FRAME_MAX];
  stk_slot_e         sbuf_q [FRAME_MAX];
  logic [IDX_W-1:0]  last_q, idx_q;
  logic              active_q, push_q;

  always_comb begin
    for (int i = 0; i < FRAME_MAX; i++) begin
      dbuf_d[i] = '0;
      sbuf_d[i] = SL_DATA;
    end
    last_d = '0;
    push_d = 1'b0;
    unique case (cmd_i)
      CMD_PUSH: begin
        push_d = 1'b1;
        dbuf_d[0] = data_i;
      end
      CMD_CALL: begin
        push_d = 1'b1;
        last_d = IDX_W'(1);
        dbuf_d[0] = pc_i[DATA_W-1:0];       sbuf_d[0] = SL_PCL;
        dbuf_d[1] = pc_i[2*DATA_W-1:DATA_W]; sbuf_d[1] = SL_PCH;
      end
      CMD_INT: begin
        push_d = 1'b1;
        last_d = IDX_W'(4);
        dbuf_d[0] = pc_i[DATA_W-1:0];       sbuf_d[0] = SL_PCL;
        dbuf_d[1] = pc_i[2*DATA_W-1:DATA_W]; sbuf_d[1] = SL_PCH;
        dbuf_d[2] = x_i;                    sbuf_d[2] = SL_X;
        dbuf_d[3] = a_i;                    sbuf_d[3] = SL_A;
        dbuf_d[4] = cc_i;                   sbuf_d[4] = SL_CC;
      end
      CMD_RET: begin
        last_d = IDX_W'(1);
        sbuf_d[0] = SL_PCH;
        sbuf_d[1] = SL_PCL;
      end
      CMD_IRET: begin
        last_d = IDX_W'(4);
        sbuf_d[0] = SL_CC;
        sbuf_d[1] = SL_A;
        sbuf_d[2] = SL_X;
        sbuf_d[3] = SL_PCH;
        sbuf_d[4] = SL_PCL;
      end
      default: ;  // single pop uses defaults
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      push_q   <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      for (int i = 0; i < FRAME_MAX; i++) begin
        dbuf_q[i] <= '0;
        sbuf_q[i] <= SL_DATA;
      end
    end else if (start_i) begin
      active_q <= 1'b1;
      push_q   <= push_d;
      idx_q    <= '0;
      last_q   <= last_d;
      for (int i = 0; i < FRAME_MAX; i++) begin
        dbuf_q[i] <= dbuf_d[i];
        sbuf_q[i] <= sbuf_d[i];
      end
    end else if (active_q) begin
      if (idx_q == last_q) active_q <= 1'b0;
      else                 idx_q    <= idx_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign push_o   = push_q;
  assign byte_o   = dbuf_q[idx_q];
  assign slot_o   = sbuf_q[idx_q];
endmodule

// File: rtl/stk_engine.sv
module stk_engine
  import stk_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          PAGE_W  = 8,
  parameter logic [PAGE_W-1:0] PAGE_ID = 8'h01,
  localparam int         LO_W    = DATA_W,
  localparam int         ADDR_W  = PAGE_W + LO_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [3:0]          cmd_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [2*DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0]   x_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   cc_i,
  output logic [ADDR_W-1:0]   sp_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_we_o,
  output logic                mem_re_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [2:0]          slot_o,
  output logic                busy_o
);
  stk_cmd_e        cmd;
  stk_slot_e       slot;
  logic            accept, is_frame, start, active, push;
  logic [LO_W-1:0] lo, lo_up;
  logic [DATA_W-1:0] seq_byte;

  assign cmd    = stk_cmd_e'(cmd_i);
  assign accept = cmd_valid_i && !active;

  always_comb begin
    unique case (cmd)
      CMD_PUSH, CMD_POP, CMD_CALL, CMD_RET, CMD_INT, CMD_IRET: is_frame = 1'b1;
      default: is_frame = 1'b0;
    endcase
  end
  assign start = accept && is_frame;

  stk_ptr_reg #(.LO_W(LO_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rsp_i    (accept && cmd == CMD_RSP),
    .ld_i     (accept && cmd == CMD_LOAD),
    .ld_val_i (data_i),
    .dec_i    (active && push),
    .inc_i    (active && !push),
    .lo_o     (lo)
  );

  stk_frame_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cmd_i    (cmd),
    .data_i   (data_i),
    .pc_i     (pc_i),
    .x_i      (x_i),
    .a_i      (a_i),
    .cc_i     (cc_i),
    .active_o (active),
    .push_o   (push),
    .byte_o   (seq_byte),
    .slot_o   (slot)
  );

  // pop pre-increments: read at the slot above the free one
  assign lo_up       = lo + 1'b1;
  assign sp_o        = {PAGE_ID, lo};
  assign mem_addr_o  = {PAGE_ID, (active && !push) ? lo_up : lo};
  assign mem_we_o    = active && push;
  assign mem_re_o    = active && !push;
  assign mem_wdata_o = (active && push) ? seq_byte : '0;
  assign slot_o      = slot;
  assign busy_o      = active;
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
  parameter int LO_W   = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [3:0]        cmd_i,
  input logic [ADDR_W-1:0] sp_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              busy_o
);
  assert_push_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == sp_o);

  assert_push_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o[LO_W-1:0] == LO_W'($past(sp_o[LO_W-1:0]) - 1'b1));

  assert_pop_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> mem_addr_o[LO_W-1:0] == LO_W'(sp_o[LO_W-1:0] + 1'b1));

  assert_pop_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> sp_o[LO_W-1:0] == LO_W'($past(sp_o[LO_W-1:0]) + 1'b1));

  assert_one_byte_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, mem_re_o}) && (busy_o == (mem_we_o || mem_re_o)));

  assert_rsp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && cmd_i == 4'd7) |=> sp_o[LO_W-1:0] == '1);

  assert_idle_no_move_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cmd_valid_i) |=> $stable(sp_o) && !busy_o);
endmodule

bind stk_engine stk_engine_chk #(.LO_W(LO_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .sp_o        (sp_o),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .busy_o      (busy_o)
);

// File: tb/stk_engine_tb.sv
module stk_engine_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [3:0]  cmd_i = '0;
  logic [7:0]  data_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  x_i = '0, a_i = '0, cc_i = '0;
  logic [15:0] sp_o, mem_addr_o;
  logic        mem_we_o, mem_re_o, busy_o;
  logic [7:0]  mem_wdata_o;
  logic [2:0]  slot_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  stk_engine u_dut (.*);

  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [2:0]  slot;
    string       req;
  } exp_t;

  exp_t       q[$];
  logic [7:0] msp = 8'hFF;
  int         checks = 0, errors = 0;
  bit         done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void exp_wr(input logic [7:0] d, input logic [2:0] s, input string r);
    q.push_back('{1'b1, {8'h01, msp}, d, s, r});
    msp = msp - 8'd1;
  endfunction

  function automatic void exp_rd(input logic [2:0] s, input string r);
    msp = msp + 8'd1;
    q.push_back('{1'b0, {8'h01, msp}, 8'h00, s, r});
  endfunction

  // monitor: compare each strobed byte against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && (mem_we_o || mem_re_o)) begin
      if (q.size() == 0) begin
        chk("R10 unexpected strobe", {mem_we_o, mem_re_o}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.req, " dir"}, mem_we_o, e.we);
        chk({e.req, " R2 addr"}, mem_addr_o, e.addr);
        chk({e.req, " slot"}, slot_o, e.slot);
        if (e.we) chk({e.req, " data"}, mem_wdata_o, e.wd);
      end
    end
  end

  // driver: present one command for one cycle; ign = expected to be dropped
  task automatic send(input logic [3:0] c, input logic [7:0] d, input logic [15:0] pc,
                      input logic [7:0] x, input logic [7:0] a, input logic [7:0] cc,
                      input bit ign);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = c; data_i = d; pc_i = pc; x_i = x; a_i = a; cc_i = cc;
    if (!ign) begin
      case (c)
        4'd1: exp_wr(d, 3'd5, "R3 push");
        4'd2: exp_rd(3'd5, "R4 pop");
        4'd3: begin exp_wr(pc[7:0], 3'd0, "R7 call"); exp_wr(pc[15:8], 3'd1, "R7 call"); end
        4'd4: begin exp_rd(3'd1, "R9 ret"); exp_rd(3'd0, "R9 ret"); end
        4'd5: begin
          exp_wr(pc[7:0], 3'd0, "R8 int"); exp_wr(pc[15:8], 3'd1, "R8 int");
          exp_wr(x, 3'd2, "R8 int"); exp_wr(a, 3'd3, "R8 int"); exp_wr(cc, 3'd4, "R8 int");
        end
        4'd6: begin
          exp_rd(3'd4, "R9 iret"); exp_rd(3'd3, "R9 iret"); exp_rd(3'd2, "R9 iret");
          exp_rd(3'd1, "R9 iret"); exp_rd(3'd0, "R9 iret");
        end
        4'd7: msp = 8'hFF;
        4'd8: msp = d;
        default: ;
      endcase
    end
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic do_cmd(input logic [3:0] c, input logic [7:0] d, input string r);
    send(c, d, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    wait_idle();
    chk({r, " sp"}, sp_o, {8'h01, msp});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 sp", sp_o, 16'h01FF);
    chk("R1 busy", busy_o, 0);
    chk("R1 strobes", {mem_we_o, mem_re_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 / R4 single bytes
    do_cmd(4'd1, 8'hA5, "R3");
    do_cmd(4'd1, 8'h3C, "R3");
    do_cmd(4'd2, 8'h00, "R4");
    do_cmd(4'd2, 8'h00, "R4");

    // R11 nop
    do_cmd(4'd0, 8'h55, "R11 nop");

    // R6 load and stack reset
    do_cmd(4'd8, 8'h80, "R6 load");
    chk("R6 load value", sp_o, 16'h0180);
    do_cmd(4'd7, 8'h00, "R6 rsp");
    chk("R6 rsp value", sp_o, 16'h01FF);

    // R7 call and R9 return
    send(4'd3, 8'h0, 16'h1234, 8'h0, 8'h0, 8'h0, 1'b0);
    wait_idle();
    chk("R7 sp after call", sp_o, 16'h01FD);
    do_cmd(4'd4, 8'h0, "R9 ret");
    chk("R9 sp after ret", sp_o, 16'h01FF);

    // R8 interrupt entry with busy length and first-strobe timing
    send(4'd5, 8'h0, 16'hBEEF, 8'h11, 8'h22, 8'hE8, 1'b0);
    chk("R11 first strobe", mem_we_o, 1);
    begin
      int n = 0;
      while (busy_o) begin n++; @(negedge clk_i); end
      chk("R10 busy cycles", n, 5);
    end
    chk("R8 sp after int", sp_o, 16'h01FA);
    do_cmd(4'd6, 8'h0, "R9 iret");
    chk("R9 sp after iret", sp_o, 16'h01FF);

    // R5 wrap both ways
    do_cmd(4'd8, 8'h00, "R5 load");
    do_cmd(4'd1, 8'h77, "R5 push wrap");
    chk("R5 push wrap sp", sp_o, 16'h01FF);
    do_cmd(4'd2, 8'h00, "R5 pop wrap");
    chk("R5 pop wrap sp", sp_o, 16'h0100);
    do_cmd(4'd8, 8'h02, "R5 load");
    send(4'd5, 8'h0, 16'hC0DE, 8'h01, 8'h02, 8'h03, 1'b0);
    wait_idle();
    chk("R5 int across page bottom", sp_o, 16'h01FD);
    do_cmd(4'd6, 8'h0, "R5 iret across page bottom");
    chk("R5 iret sp", sp_o, 16'h0102);

    // R10 commands while busy are dropped
    do_cmd(4'd7, 8'h0, "R6 rsp");
    send(4'd5, 8'h0, 16'h4321, 8'hAA, 8'hBB, 8'hCC, 1'b0);
    send(4'd8, 8'h40, 16'h0, 8'h0, 8'h0, 8'h0, 1'b1);
    send(4'd1, 8'h99, 16'h0, 8'h0, 8'h0, 8'h0, 1'b1);
    wait_idle();
    chk("R10 ignored while busy sp", sp_o, 16'h01FA);
    do_cmd(4'd6, 8'h0, "R9 iret");

    repeat (4) @(negedge clk_i);
    chk("R10 scoreboard drained", q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule